// File: doc/BRIEF.md
# Trigger-linked timer

A general-purpose counter timer meant to sit in a bank of timers that trigger one another. A prescaler divides the counting source, and the counter runs up or down between zero and an auto-reload limit. The limit and the prescaler ratio can be held in shadow registers until the next update event. Software controls the block through a small register bus that carries an address, write data, a write strobe and combinational read data.

The block drives one trigger output for its neighbours. A mode field picks what that output carries: the counter enable level, a pulse on update, a pulse on reinitialisation, a pulse on a compare match, or one of four external output-compare references. One of four trigger inputs, picked by a select field, is synchronised and can then gate the counter, restart it, start it, or act as its counting clock.

Register map (address: content): 0 control (bit 0 run, bit 1 count down, bit 2 limit preload enable); 1 mode (bits 2:0 output mode, bits 6:4 slave mode, bits 9:8 trigger select); 2 event (write bit 0 = 1 to force an update, reads 0); 3 counter; 4 prescaler; 5 reload limit; 6 compare value; 7 reads 0. Reads of 4 and 5 return the last written value, not the active one.

Top module: `trig_timer`

## Requirements
- R1: After reset, control, mode, counter, prescaler and compare read 0, the reload limit reads all ones, and trgo_o is 0.
- R2: Counting up with run set, the counter steps once per prescaled tick and returns from the active limit to 0, so it repeats every (prescaler+1)*(limit+1) clocks.
- R3: A prescaler write is held until the next update event; after it, the counter steps once every prescaler+1 enabled clocks, the first step coming prescaler+1 clocks after the update.
- R4: With control bit 2 set, a write to the limit is held until the next update event; with it clear, the write takes effect at once.
- R5: Writing 1 to event bit 0 is an update event: it loads both held values, clears the prescaler, and sets the counter to 0 when counting up or to the new limit when counting down, in the same clock.
- R6: With control bit 1 set, the counter steps down and goes from 0 to the limit, and that underflow is an update event.
- R7: trgo_o is a flop; for output mode 0 it pulses one clock after a reinitialisation, for 1 it equals the run bit, for 2 it pulses after every update event, for 3 it pulses when a counter step lands on the compare value, and for 4 to 7 it follows oc_ref_i[mode-4] one clock later.
- R8: Mode bits 9:8 pick trig_i[n] by index n; the unselected trigger inputs have no effect on the counter.
- R9: The selected trigger passes two synchroniser flops: a level change at trig_i acts on the counter at the third rising clock edge after it.
- R10: Slave mode 5 (gated): the counter counts only while the synchronised trigger is high.
- R11: Slave mode 6 (triggered): a synchronised rising edge sets the run bit; the counter then runs until software clears it.
- R12: Slave mode 7 (external clock): each synchronised rising edge of the trigger is one prescaler input; the internal clock alone does not count.
- R13: Slave mode 4 (reset): a synchronised rising edge reinitialises the counter as in R5 while it keeps running on the internal clock; slave modes 0 to 3 run freely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wdata_i | input | CNT_W | Register write data |
| we_i | input | 1 | Register write strobe |
| rdata_o | output | CNT_W | Register read data, combinational from addr_i |
| trig_i | input | NUM_TRIG | Trigger inputs from other timers, asynchronous |
| oc_ref_i | input | 4 | Output-compare references that output modes 4 to 7 forward |
| trgo_o | output | 1 | Trigger output to other timers |

## Verification
The counter is run on the internal clock with a prescaler of 0 and of 2, up and down, with the limit written both directly and through the preload shadow, so that wrap values and step spacing separate the active from the pending settings. The trigger input is driven as a held level on the selected and on an unselected line, as a single rising edge, and as a pulse train, which tells the gated, triggered, reset and external-clock slave modes apart and pins the two-flop latency to a clock. Each output mode is tried against the event that should drive it, and the clock in which trgo_o rises and falls is checked against the counter value of that clock.

// File: rtl/trig_timer_pkg.sv
package trig_timer_pkg;

  localparam int unsigned ADDR_W = 3;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_CTRL = addr_t'(0);
  localparam addr_t A_MODE = addr_t'(1);
  localparam addr_t A_EVT  = addr_t'(2);
  localparam addr_t A_CNT  = addr_t'(3);
  localparam addr_t A_PSC  = addr_t'(4);
  localparam addr_t A_ARR  = addr_t'(5);
  localparam addr_t A_CMP  = addr_t'(6);

  localparam int unsigned CTRL_RUN    = 0;
  localparam int unsigned CTRL_DOWN   = 1;
  localparam int unsigned CTRL_PRE    = 2;
  localparam int unsigned MODE_MM_LSB = 0;
  localparam int unsigned MODE_SM_LSB = 4;
  localparam int unsigned MODE_TS_LSB = 8;
  localparam int unsigned EVT_UG      = 0;

  typedef enum logic [2:0] {
    MM_RESET  = 3'd0,
    MM_ENABLE = 3'd1,
    MM_UPDATE = 3'd2,
    MM_CMP    = 3'd3,
    MM_OC1    = 3'd4,
    MM_OC2    = 3'd5,
    MM_OC3    = 3'd6,
    MM_OC4    = 3'd7
  } mm_e;

  typedef enum logic [2:0] {
    SM_FREE   = 3'd0,
    SM_RSV1   = 3'd1,
    SM_RSV2   = 3'd2,
    SM_RSV3   = 3'd3,
    SM_RESET  = 3'd4,
    SM_GATED  = 3'd5,
    SM_TRIG   = 3'd6,
    SM_EXTCLK = 3'd7
  } sm_e;

endpackage

// File: rtl/trig_sel_sync.sv
module trig_sel_sync #(
  parameter int unsigned NUM_TRIG    = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SEL_W      = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic                lvl_o,
  output logic                rise_o
);

  // every line keeps its own chain so a select change sees settled data
  logic [SYNC_STAGES-1:0][NUM_TRIG-1:0] sync_q;
  logic                                 prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= trig_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign lvl_o = sync_q[SYNC_STAGES-1][sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_o;
  end

  assign rise_o = lvl_o & ~prev_q;

endmodule

// File: rtl/trig_prescaler.sv
module trig_prescaler #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         src_i,
  input  logic         clear_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);

  logic [W-1:0] cnt_q;

  assign tick_o = src_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (src_i)   cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end

endmodule

// File: rtl/trig_counter.sv
module trig_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         down_i,
  input  logic         load_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] lim_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_d_o,
  output logic         wrap_o
);

  logic [W-1:0] cnt_q;
  logic         at_lim;
  logic [W-1:0] start_val;

  assign at_lim    = down_i ? (cnt_q == '0) : (cnt_q == lim_i);
  assign start_val = down_i ? reload_i : '0;
  assign wrap_o    = tick_i && !load_i && !wr_i && at_lim;

  always_comb begin
    cnt_d_o = cnt_q;
    if (load_i)      cnt_d_o = start_val;
    else if (wr_i)   cnt_d_o = wdata_i;
    else if (tick_i) begin
      if (at_lim)      cnt_d_o = start_val;
      else if (down_i) cnt_d_o = cnt_q - 1'b1;
      else             cnt_d_o = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d_o;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/trig_master.sv
module trig_master
  import trig_timer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  mm_e        mode_i,
  input  logic       reinit_i,
  input  logic       upd_i,
  input  logic       cmp_hit_i,
  input  logic       run_i,
  input  logic [3:0] oc_ref_i,
  output logic       trgo_o
);

  logic trgo_d, trgo_q;

  always_comb begin
    case (mode_i)
      MM_RESET:  trgo_d = reinit_i;
      MM_ENABLE: trgo_d = run_i;
      MM_UPDATE: trgo_d = upd_i;
      MM_CMP:    trgo_d = cmp_hit_i;
      default:   trgo_d = oc_ref_i[mode_i[1:0]];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trgo_q <= 1'b0;
    else         trgo_q <= trgo_d;
  end

  assign trgo_o = trgo_q;

endmodule

// File: rtl/trig_timer.sv
module trig_timer
  import trig_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned NUM_TRIG    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [CNT_W-1:0]    wdata_i,
  input  logic                we_i,
  output logic [CNT_W-1:0]    rdata_o,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic [3:0]          oc_ref_i,
  output logic                trgo_o
);

  localparam int unsigned TS_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

  logic             run_q, down_q, pre_q;
  mm_e              mm_q;
  sm_e              sm_q;
  logic [TS_W-1:0]  ts_q;
  logic [CNT_W-1:0] cmp_q, psc_pre_q, psc_act_q, arr_pre_q, arr_act_q;

  logic wr_ctrl, wr_mode, wr_evt, wr_cnt, wr_psc, wr_arr, wr_cmp;
  logic ug, reinit, run_d, cnt_src, tick, wrap, upd_evt, cmp_hit;
  logic trig_lvl, trig_rise;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign wr_ctrl = we_i && (addr_i == A_CTRL);
  assign wr_mode = we_i && (addr_i == A_MODE);
  assign wr_evt  = we_i && (addr_i == A_EVT);
  assign wr_cnt  = we_i && (addr_i == A_CNT);
  assign wr_psc  = we_i && (addr_i == A_PSC);
  assign wr_arr  = we_i && (addr_i == A_ARR);
  assign wr_cmp  = we_i && (addr_i == A_CMP);
  assign ug      = wr_evt && wdata_i[EVT_UG];

  trig_sel_sync #(
    .NUM_TRIG   (NUM_TRIG),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(trig_i),
    .sel_i (ts_q),
    .lvl_o (trig_lvl),
    .rise_o(trig_rise)
  );

  // slave control
  always_comb begin
    case (sm_q)
      SM_GATED:  cnt_src = run_q && trig_lvl;
      SM_EXTCLK: cnt_src = run_q && trig_rise;
      default:   cnt_src = run_q;
    endcase
  end

  assign reinit = ug || ((sm_q == SM_RESET) && trig_rise);

  always_comb begin
    if (wr_ctrl)                             run_d = wdata_i[CTRL_RUN];
    else if ((sm_q == SM_TRIG) && trig_rise) run_d = 1'b1;
    else                                     run_d = run_q;
  end

  trig_prescaler #(.W(CNT_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (cnt_src),
    .clear_i(reinit),
    .div_i  (psc_act_q),
    .tick_o (tick)
  );

  trig_counter #(.W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .down_i  (down_q),
    .load_i  (reinit),
    .wr_i    (wr_cnt),
    .wdata_i (wdata_i),
    .lim_i   (arr_act_q),
    .reload_i(arr_pre_q),
    .cnt_o   (cnt_q),
    .cnt_d_o (cnt_d),
    .wrap_o  (wrap)
  );

  assign upd_evt = wrap || reinit;
  assign cmp_hit = (tick || reinit) && (cnt_d == cmp_q);

  trig_master u_mst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mm_q),
    .reinit_i (reinit),
    .upd_i    (upd_evt),
    .cmp_hit_i(cmp_hit),
    .run_i    (run_d),
    .oc_ref_i (oc_ref_i),
    .trgo_o   (trgo_o)
  );

  // register file
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      down_q <= 1'b0;
      pre_q  <= 1'b0;
      mm_q   <= MM_RESET;
      sm_q   <= SM_FREE;
      ts_q   <= '0;
      cmp_q  <= '0;
    end else begin
      run_q <= run_d;
      if (wr_ctrl) begin
        down_q <= wdata_i[CTRL_DOWN];
        pre_q  <= wdata_i[CTRL_PRE];
      end
      if (wr_mode) begin
        mm_q <= mm_e'(wdata_i[MODE_MM_LSB +: 3]);
        sm_q <= sm_e'(wdata_i[MODE_SM_LSB +: 3]);
        ts_q <= wdata_i[MODE_TS_LSB +: TS_W];
      end
      if (wr_cmp) cmp_q <= wdata_i;
    end
  end

  // shadowed limit and prescaler
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_pre_q <= '0;
      psc_act_q <= '0;
      arr_pre_q <= '1;
      arr_act_q <= '1;
    end else begin
      if (wr_psc) psc_pre_q <= wdata_i;
      if (upd_evt) psc_act_q <= psc_pre_q;
      if (wr_arr) arr_pre_q <= wdata_i;
      if (wr_arr && !pre_q) arr_act_q <= wdata_i;
      else if (upd_evt)     arr_act_q <= arr_pre_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[CTRL_RUN]  = run_q;
        rdata_o[CTRL_DOWN] = down_q;
        rdata_o[CTRL_PRE]  = pre_q;
      end
      A_MODE: begin
        rdata_o[MODE_MM_LSB +: 3]    = mm_q;
        rdata_o[MODE_SM_LSB +: 3]    = sm_q;
        rdata_o[MODE_TS_LSB +: TS_W] = ts_q;
      end
      A_CNT:   rdata_o = cnt_q;
      A_PSC:   rdata_o = psc_pre_q;
      A_ARR:   rdata_o = arr_pre_q;
      A_CMP:   rdata_o = cmp_q;
      default: rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/trig_timer_chk.sv
module trig_timer_chk
  import trig_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick,
  input logic             reinit,
  input logic             ug,
  input logic             upd_evt,
  input logic             wr_cnt,
  input logic             wr_arr,
  input logic             wr_ctrl,
  input logic             run_q,
  input logic             down_q,
  input logic             pre_q,
  input mm_e              mm_q,
  input sm_e              sm_q,
  input logic             trig_lvl,
  input logic             trig_rise,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] arr_act_q,
  input logic [CNT_W-1:0] psc_act_q,
  input logic             trgo_o
);

  a_r2_up_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !down_q && cnt_q == arr_act_q && !reinit && !wr_cnt) |=> (cnt_q == '0));

  a_r6_down_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && down_q && cnt_q == '0 && !reinit && !wr_cnt && !wr_arr) |=> (cnt_q == arr_act_q));

  a_r5_force_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ug && !down_q) |=> (cnt_q == '0));

  a_r3_psc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_evt |=> $stable(psc_act_q));

  a_r4_arr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_q && !upd_evt) |=> $stable(arr_act_q));

  a_r7_enable_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_q == MM_ENABLE && $past(mm_q) == MM_ENABLE) |-> (trgo_o == run_q));

  a_r7_update_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_q == MM_UPDATE && upd_evt) |=> trgo_o);

  a_r10_gate_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sm_q == SM_GATED && !trig_lvl && !reinit && !wr_cnt) |=> $stable(cnt_q));

  a_r11_trig_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sm_q == SM_TRIG && trig_rise && !wr_ctrl) |=> run_q);

  a_r12_ext_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sm_q == SM_EXTCLK && !trig_rise && !reinit && !wr_cnt) |=> $stable(cnt_q));

  a_r13_reset_slave: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sm_q == SM_RESET && trig_rise && !down_q) |=> (cnt_q == '0));

endmodule

bind trig_timer trig_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick     (tick),
  .reinit   (reinit),
  .ug       (ug),
  .upd_evt  (upd_evt),
  .wr_cnt   (wr_cnt),
  .wr_arr   (wr_arr),
  .wr_ctrl  (wr_ctrl),
  .run_q    (run_q),
  .down_q   (down_q),
  .pre_q    (pre_q),
  .mm_q     (mm_q),
  .sm_q     (sm_q),
  .trig_lvl (trig_lvl),
  .trig_rise(trig_rise),
  .cnt_q    (cnt_q),
  .arr_act_q(arr_act_q),
  .psc_act_q(psc_act_q),
  .trgo_o   (trgo_o)
);

// File: tb/trig_timer_tb.sv
module trig_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0;
  logic [15:0] rdata;
  logic [3:0]  trig = '0;
  logic [3:0]  ocref = '0;
  logic        trgo;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam logic [2:0] R_CTRL = 3'd0, R_MODE = 3'd1, R_EVT = 3'd2, R_CNT = 3'd3,
                         R_PSC = 3'd4, R_ARR = 3'd5, R_CMP = 3'd6;

  always #4 clk = ~clk;

  trig_timer u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .addr_i  (addr),
    .wdata_i (wdata),
    .we_i    (we),
    .rdata_o (rdata),
    .trig_i  (trig),
    .oc_ref_i(ocref),
    .trgo_o  (trgo)
  );

  typedef struct {
    string       tag;
    logic [15:0] exp;
  } item_t;

  item_t       exp_q[$];
  logic [15:0] obs_q[$];
  event        item_ev;

  task automatic drain();
    while (exp_q.size() > 0 && obs_q.size() > 0) begin
      item_t       it;
      logic [15:0] got;
      it  = exp_q.pop_front();
      got = obs_q.pop_front();
      total++;
      if (got !== it.exp) begin
        bad++;
        $display("FAIL %s: got %0h expected %0h", it.tag, got, it.exp);
      end
    end
  endtask

  initial forever begin
    @(item_ev);
    drain();
  end

  task automatic expect_val(input string tag, input logic [15:0] got, input logic [15:0] exp);
    exp_q.push_back('{tag, exp});
    obs_q.push_back(got);
    ->item_ev;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] a, input logic [15:0] exp);
    addr = a;
    #1;
    expect_val(tag, rdata, exp);
  endtask

  task automatic chk_trgo(input string tag, input logic exp);
    expect_val(tag, {15'd0, trgo}, {15'd0, exp});
  endtask

  function automatic logic [15:0] mode(input int mm, input int sm, input int ts);
    return 16'((ts << 8) | (sm << 4) | mm);
  endfunction

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // reset state
    chk_reg("R1 ctrl", R_CTRL, 16'h0000);
    chk_reg("R1 mode", R_MODE, 16'h0000);
    chk_reg("R1 cnt",  R_CNT,  16'h0000);
    chk_reg("R1 psc",  R_PSC,  16'h0000);
    chk_reg("R1 arr",  R_ARR,  16'hFFFF);
    chk_reg("R1 cmp",  R_CMP,  16'h0000);
    chk_trgo("R1 trgo", 1'b0);

    // up counting, wrap, update pulse
    wr(R_ARR, 16'd9);
    wr(R_CNT, 16'd0);
    wr(R_MODE, mode(2, 0, 0));
    wr(R_CTRL, 16'h0001);
    cyc(9);
    chk_reg("R2 before wrap", R_CNT, 16'd9);
    chk_trgo("R7 no update yet", 1'b0);
    cyc(1);
    chk_reg("R2 wrap to zero", R_CNT, 16'd0);
    chk_trgo("R7 update pulse", 1'b1);
    cyc(1);
    chk_reg("R2 after wrap", R_CNT, 16'd1);
    chk_trgo("R7 update pulse ends", 1'b0);

    // prescaler shadow, forced update
    wr(R_CTRL, 16'h0000);
    wr(R_CNT, 16'd0);
    wr(R_PSC, 16'd2);
    chk_reg("R3 psc readback", R_PSC, 16'd2);
    wr(R_CTRL, 16'h0001);
    cyc(3);
    chk_reg("R3 psc pending", R_CNT, 16'd3);
    wr(R_EVT, 16'h0001);
    chk_reg("R5 force clears cnt", R_CNT, 16'd0);
    chk_trgo("R5 force is update", 1'b1);
    cyc(2);
    chk_reg("R3 divided hold", R_CNT, 16'd0);
    cyc(1);
    chk_reg("R3 divided step", R_CNT, 16'd1);
    cyc(3);
    chk_reg("R3 divided period", R_CNT, 16'd2);

    // limit preload
    wr(R_CTRL, 16'h0000);
    wr(R_PSC, 16'd0);
    wr(R_EVT, 16'h0001);
    wr(R_CTRL, 16'h0004);
    wr(R_ARR, 16'd4);
    chk_reg("R4 arr readback", R_ARR, 16'd4);
    wr(R_CNT, 16'd8);
    wr(R_CTRL, 16'h0005);
    cyc(1);
    chk_reg("R4 old limit", R_CNT, 16'd9);
    cyc(1);
    chk_reg("R4 wrap at old limit", R_CNT, 16'd0);
    cyc(5);
    chk_reg("R4 new limit after update", R_CNT, 16'd0);

    // down counting
    wr(R_CTRL, 16'h0002);
    wr(R_ARR, 16'd5);
    wr(R_EVT, 16'h0001);
    chk_reg("R5 force loads limit down", R_CNT, 16'd5);
    wr(R_CTRL, 16'h0003);
    cyc(5);
    chk_reg("R6 down to zero", R_CNT, 16'd0);
    chk_trgo("R6 no underflow yet", 1'b0);
    cyc(1);
    chk_reg("R6 underflow reload", R_CNT, 16'd5);
    chk_trgo("R6 underflow update", 1'b1);

    // gated slave
    wr(R_CTRL, 16'h0000);
    wr(R_ARR, 16'd100);
    wr(R_CNT, 16'd0);
    wr(R_MODE, mode(1, 5, 1));
    chk_reg("R8 mode readback", R_MODE, 16'h0151);
    wr(R_CTRL, 16'h0001);
    chk_trgo("R7 enable level", 1'b1);
    cyc(5);
    chk_reg("R10 gate low", R_CNT, 16'd0);
    trig = 4'b0100;
    cyc(6);
    chk_reg("R8 unselected ignored", R_CNT, 16'd0);
    trig = 4'b0000;
    cyc(3);
    trig = 4'b0010;
    cyc(2);
    chk_reg("R9 sync latency", R_CNT, 16'd0);
    cyc(3);
    chk_reg("R10 gate high", R_CNT, 16'd3);
    trig = 4'b0000;
    cyc(6);
    chk_reg("R10 gate close latency", R_CNT, 16'd5);

    // triggered slave
    wr(R_CTRL, 16'h0000);
    wr(R_CNT, 16'd0);
    wr(R_MODE, mode(1, 6, 3));
    cyc(4);
    chk_reg("R11 idle run", R_CTRL, 16'h0000);
    chk_reg("R11 idle cnt", R_CNT, 16'd0);
    chk_trgo("R7 enable low", 1'b0);
    trig = 4'b1000;
    cyc(3);
    chk_reg("R11 run set", R_CTRL, 16'h0001);
    chk_reg("R11 cnt at start", R_CNT, 16'd0);
    chk_trgo("R11 enable follows", 1'b1);
    cyc(1);
    chk_reg("R11 first step", R_CNT, 16'd1);
    trig = 4'b0000;
    cyc(5);
    chk_reg("R11 keeps running", R_CNT, 16'd6);

    // external clock slave
    wr(R_CTRL, 16'h0000);
    wr(R_CNT, 16'd0);
    wr(R_MODE, mode(2, 7, 0));
    wr(R_CTRL, 16'h0001);
    cyc(5);
    chk_reg("R12 no internal count", R_CNT, 16'd0);
    for (int i = 0; i < 4; i++) begin
      trig = 4'b0001;
      cyc(3);
      trig = 4'b0000;
      cyc(3);
    end
    chk_reg("R12 edge count", R_CNT, 16'd4);

    // reset slave
    wr(R_MODE, mode(0, 4, 0));
    cyc(5);
    trig = 4'b0001;
    cyc(3);
    chk_reg("R13 trigger clears", R_CNT, 16'd0);
    chk_trgo("R7 reset pulse", 1'b1);
    cyc(1);
    chk_reg("R13 runs on", R_CNT, 16'd1);
    chk_trgo("R7 reset pulse ends", 1'b0);
    trig = 4'b0000;

    // compare pulse
    wr(R_CTRL, 16'h0000);
    wr(R_MODE, mode(3, 0, 0));
    wr(R_CMP, 16'd3);
    wr(R_ARR, 16'd9);
    wr(R_CNT, 16'd0);
    wr(R_CTRL, 16'h0001);
    cyc(2);
    chk_trgo("R7 compare not yet", 1'b0);
    cyc(1);
    chk_reg("R7 compare cnt", R_CNT, 16'd3);
    chk_trgo("R7 compare pulse", 1'b1);
    cyc(1);
    chk_trgo("R7 compare pulse ends", 1'b0);

    // reference forwarding
    wr(R_MODE, mode(6, 0, 0));
    ocref = 4'b0100;
    cyc(1);
    chk_trgo("R7 ref3 high", 1'b1);
    ocref = 4'b1011;
    cyc(1);
    chk_trgo("R7 ref3 low", 1'b0);
    wr(R_MODE, mode(7, 0, 0));
    cyc(1);
    chk_trgo("R7 ref4 high", 1'b1);
    chk_reg("R7 mode readback", R_MODE, 16'h0007);
    chk_reg("R5 event reads zero", R_EVT, 16'h0000);

    cyc(2);
    drain();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      drain();
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule